// File: doc/BRIEF.md
# Logic analyzer capture controller

This block sits between a sampled parallel input bus and a capture stream. Input words pass through a register synchronizer and are then thinned out by a programmable decimator. Next comes a history line of programmable depth, which delays the decimated stream so that words taken before a trigger can still be forwarded. A capture sequencer reacts to a one-cycle trigger pulse. It discards a programmable number of decimated words and then forwards words as a valid/data stream.

The sequencer has two modes. In single-shot mode it forwards a fixed count of words and then re-arms. In streaming mode it forwards every word without end once it has been triggered. The synchronized input word is also presented on a status port, so software or a neighbouring block can read the live pin state.

Top module: `la_capture_ctrl`

## Requirements
- R1: The decimator takes one word out of every `cfg_div`+1 cycles on which `smp_en` is high; cycles with `smp_en` low are not counted. The first enabled cycle after reset is taken.
- R2: With history depth `cfg_hist` = H, each forwarded word is the decimated word taken H decimated words earlier. For H = 0 the history line is bypassed. A word taken at clock edge n (that is, `din` as sampled at edge n-2) appears on `out_data` with `out_valid` high after edge n+1.
- R3: `din_status` equals `din` as sampled two clock edges earlier (two synchronizer stages); it reads 0 during reset.
- R4: Only a trigger pulse moves the block out of idle. After the trigger, the first `cfg_delay` decimated words taken at or after the trigger edge are discarded. A decimated word counts as taken at or after the trigger if it is loaded on the trigger edge itself or later.
- R5: In single-shot mode (`cfg_stream` = 0), exactly `cfg_len`+1 words are forwarded per trigger, after which the block returns to idle and accepts a new trigger.
- R6: A trigger pulse that arrives while the block is delaying or capturing has no effect. A trigger is accepted only at an edge at least two edges after the last forwarded word was taken.
- R7: In streaming mode (`cfg_stream` = 1), every decimated word after the delay is forwarded for as long as streaming stays set, with no further trigger.
- R8: A change of `cfg_hist` to a nonzero depth H flushes the history line. `out_valid` stays low for the word taken in the cycle of the change and for the next H decimated words.
- R9: Synchronous active-high reset returns the sequencer to idle, clears the decimator phase, the fill count and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample enable; decimator counts only these cycles |
| din | input | DATA_W (16) | Raw input word |
| trig | input | 1 | One-cycle trigger pulse |
| cfg_div | input | DIV_W (8) | Decimation ratio minus one |
| cfg_hist | input | HIST_W (5) | History depth in decimated words, clamped to HIST_MAX |
| cfg_delay | input | CNT_W (16) | Decimated words discarded after a trigger |
| cfg_len | input | CNT_W (16) | Single-shot capture length minus one |
| cfg_stream | input | 1 | 1 selects streaming, 0 single-shot |
| din_status | output | DATA_W (16) | Synchronized input word |
| out_valid | output | 1 | Captured word valid |
| out_data | output | DATA_W (16) | Captured word |

## Verification
The input bus carries a ramp whose value equals the clock edge index, so every forwarded word identifies exactly which edge it came from. The bench sweeps divider values 0 to 2, history depths 0, 1 and 3, delays 0 and 2, lengths 1 and 4, both capture modes, and sample enables that are either always on or on every other cycle. The spacing between forwarded words separates decimation from enable gating. Their absolute value separates the history depth from pipeline latency, and the first and last positions separate the trigger delay from the capture length. A second trigger is placed either inside a capture, where it must be ignored, or after it, where it must start a new window. A separate run changes the depth mid-stream and measures the refill gap.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_CAPT  = 2'd2
   } cap_state_e;

endpackage

// File: rtl/la_sync.sv
module la_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg[0] <= '0;
      else     stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg[i] <= '0;
         else     stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/la_decim.sv
module la_decim #(
   parameter int W     = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   input  logic [W-1:0]     d,
   output logic             vld,
   output logic [W-1:0]     q
);

   logic [DIV_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         vld   <= 1'b0;
         q     <= '0;
      end else begin
         vld <= 1'b0;
         if (en) begin
            if (phase == '0) begin
               vld <= 1'b1;
               q   <= d;
            end
            if (phase >= div) phase <= '0;
            else              phase <= phase + DIV_W'(1);
         end
      end
   end

endmodule

// File: rtl/la_hist.sv
module la_hist #(
   parameter int W   = 16,
   parameter int MAX = 16,
   parameter int HW  = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   input  logic [W-1:0]  in_dat,
   input  logic [HW-1:0] depth,
   output logic          out_vld,
   output logic [W-1:0]  out_dat
);

   if (MAX == 0) begin : g_bypass
      logic unused_bits;
      assign unused_bits = ^{clk, rst, depth};
      assign out_vld = in_vld;
      assign out_dat = in_dat;
   end else begin : g_line
      logic [W-1:0]  line [MAX];
      logic [HW-1:0] depth_eff;
      logic [HW-1:0] depth_q;
      logic [HW-1:0] fill;
      logic          flush;
      logic          bypass;

      assign depth_eff = (depth > HW'(MAX)) ? HW'(MAX) : depth;
      assign flush     = (depth_eff != depth_q);
      assign bypass    = (depth_eff == '0);

      // depth tracker runs through reset so a static setting never flushes
      always_ff @(posedge clk) depth_q <= depth_eff;

      always_ff @(posedge clk) begin
         if (in_vld) begin
            line[0] <= in_dat;
            for (int i = 1; i < MAX; i++) line[i] <= line[i-1];
         end
      end

      always_ff @(posedge clk) begin
         if (rst)                              fill <= '0;
         else if (flush)                       fill <= '0;
         else if (in_vld && fill < depth_eff)  fill <= fill + HW'(1);
      end

      always_comb begin
         out_dat = in_dat;
         for (int i = 0; i < MAX; i++) begin
            if (depth_eff == HW'(i + 1)) out_dat = line[i];
         end
      end

      assign out_vld = in_vld && (bypass || (!flush && fill == depth_eff));
   end

endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm
   import la_cap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig,
   input  logic             stb,
   input  logic             stream,
   input  logic [CNT_W-1:0] delay,
   input  logic [CNT_W-1:0] len,
   output cap_state_e       st
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (trig) begin
                  cnt <= '0;
                  st  <= (delay == '0) ? ST_CAPT : ST_DELAY;
               end
            end
            ST_DELAY: begin
               if (stb) begin
                  if (cnt + CNT_W'(1) >= delay) begin
                     cnt <= '0;
                     st  <= ST_CAPT;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            ST_CAPT: begin
               if (stb && !stream) begin
                  if (cnt >= len) begin
                     cnt <= '0;
                     st  <= ST_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            default: begin
               cnt <= '0;
               st  <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
   import la_cap_pkg::*;
#(
   parameter  int DATA_W      = 16,
   parameter  int DIV_W       = 8,
   parameter  int HIST_MAX    = 16,
   parameter  int CNT_W       = 16,
   parameter  int SYNC_STAGES = 2,
   localparam int HIST_W      = $clog2(HIST_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_en,
   input  logic [DATA_W-1:0] din,
   input  logic              trig,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [HIST_W-1:0] cfg_hist,
   input  logic [CNT_W-1:0]  cfg_delay,
   input  logic [CNT_W-1:0]  cfg_len,
   input  logic              cfg_stream,
   output logic [DATA_W-1:0] din_status,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   if (DATA_W < 1 || DIV_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("la_capture_ctrl: widths must be positive");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("la_capture_ctrl: at least one synchronizer stage required");
   end
   if (HIST_MAX < 0 || HIST_MAX > 1024) begin : g_bad_hist
      $error("la_capture_ctrl: HIST_MAX out of range");
   end

   logic [DATA_W-1:0] sync_q;
   logic              dec_vld;
   logic [DATA_W-1:0] dec_dat;
   logic              hist_vld;
   logic [DATA_W-1:0] hist_dat;
   cap_state_e        fsm_st;
   logic              fire;

   la_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (din),
      .q   (sync_q)
   );

   assign din_status = sync_q;

   la_decim #(.W(DATA_W), .DIV_W(DIV_W)) u_decim (
      .clk (clk),
      .rst (rst),
      .en  (smp_en),
      .div (cfg_div),
      .d   (sync_q),
      .vld (dec_vld),
      .q   (dec_dat)
   );

   la_hist #(.W(DATA_W), .MAX(HIST_MAX), .HW(HIST_W)) u_hist (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (dec_vld),
      .in_dat  (dec_dat),
      .depth   (cfg_hist),
      .out_vld (hist_vld),
      .out_dat (hist_dat)
   );

   la_cap_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .trig   (trig),
      .stb    (hist_vld),
      .stream (cfg_stream),
      .delay  (cfg_delay),
      .len    (cfg_len),
      .st     (fsm_st)
   );

   assign fire = (fsm_st == ST_CAPT) && hist_vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= fire;
         if (fire) out_data <= hist_dat;
      end
   end

endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk
   import la_cap_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int HIST_W      = 5,
   parameter int HIST_MAX    = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              trig,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] din_status,
   input logic [HIST_W-1:0] cfg_hist,
   input logic              cfg_stream,
   input logic              out_valid,
   input cap_state_e        st
);

   int unsigned age;

   always_ff @(posedge clk) begin
      if (rst)                         age <= 0;
      else if (age < SYNC_STAGES + 1)  age <= age + 1;
   end

   // R3: status word trails the raw input by the synchronizer depth
   p_sync_delay_r3: assert property (@(posedge clk) disable iff (rst)
      age >= SYNC_STAGES |-> din_status == $past(din, SYNC_STAGES));

   // R4: nothing but a trigger leaves idle
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      st == ST_IDLE && !trig |=> st == ST_IDLE);

   // R6: a trigger during the delay phase does not restart or abort
   p_delay_ignores_trig_r6: assert property (@(posedge clk) disable iff (rst)
      st == ST_DELAY && trig |=> st != ST_IDLE);

   // R7: streaming capture never ends by itself
   p_stream_stays_r7: assert property (@(posedge clk) disable iff (rst)
      st == ST_CAPT && cfg_stream |=> st == ST_CAPT);

   // R5: forwarded words only come from the capture phase
   p_valid_from_capt_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(st) == ST_CAPT);

   // R8: a new nonzero depth blanks the next output
   p_flush_blank_r8: assert property (@(posedge clk) disable iff (rst)
      cfg_hist != $past(cfg_hist) && cfg_hist != '0 &&
      cfg_hist <= HIST_W'(HIST_MAX) && $past(cfg_hist) <= HIST_W'(HIST_MAX)
      |=> !out_valid);

endmodule

bind la_capture_ctrl la_capture_chk #(
   .DATA_W      (DATA_W),
   .HIST_W      (HIST_W),
   .HIST_MAX    (HIST_MAX),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .trig       (trig),
   .din        (din),
   .din_status (din_status),
   .cfg_hist   (cfg_hist),
   .cfg_stream (cfg_stream),
   .out_valid  (out_valid),
   .st         (fsm_st)
);

// File: tb/la_capture_ctrl_test.sv
`timescale 1ns/1ps
module la_capture_ctrl_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_en = 1'b1;
   logic [15:0] din = '0;
   logic        trig = 1'b0;
   logic [7:0]  cfg_div = '0;
   logic [4:0]  cfg_hist = '0;
   logic [15:0] cfg_delay = '0;
   logic [15:0] cfg_len = '0;
   logic        cfg_stream = 1'b0;
   logic [15:0] din_status;
   logic        out_valid;
   logic [15:0] out_data;

   int n_run  = 0;
   int n_fail = 0;
   int ecnt   = 0;
   int r0     = 0;
   int p_cur  = 1;
   bit done   = 1'b0;

   la_capture_ctrl uut (
      .clk        (clk),
      .rst        (rst),
      .smp_en     (smp_en),
      .din        (din),
      .trig       (trig),
      .cfg_div    (cfg_div),
      .cfg_hist   (cfg_hist),
      .cfg_delay  (cfg_delay),
      .cfg_len    (cfg_len),
      .cfg_stream (cfg_stream),
      .din_status (din_status),
      .out_valid  (out_valid),
      .out_data   (out_data)
   );

   always #4 clk = ~clk;

   // din at edge e equals e + 100; smp_en high every p_cur-th edge from r0
   task automatic tick();
      @(posedge clk);
      ecnt++;
      @(negedge clk);
      din    = 16'(ecnt + 101);
      smp_en = (((ecnt + 1 - r0) % p_cur) == 0);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %0d expected %0d", req, ecnt, act, exp);
      end
   endtask

   task automatic do_reset(input int d, input int h, input int l, input int n,
                           input bit s, input int p);
      rst = 1'b1;
      trig = 1'b0;
      cfg_div = 8'(d);
      cfg_hist = 5'(h);
      cfg_delay = 16'(l);
      cfg_len = 16'(n);
      cfg_stream = s;
      p_cur = p;
      tick(); tick(); tick();
      check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
      check(din_status == 16'd0, "R9 R3 status in reset", int'(din_status), 0);
      r0 = ecnt + 1;
      rst = 1'b0;
      smp_en = 1'b1;
   endtask

   task automatic run_case(input int d, input int h, input int l, input int n,
                           input bit s, input int p, input int t1, input int t2);
      int stride, k1, last1, k2, ncyc;
      bit acc2;
      do_reset(d, h, l, n, s, p);
      stride = (d + 1) * p;
      k1     = (t1 + stride - 1) / stride + l;
      last1  = k1 + n;
      acc2   = !s && (t2 >= last1 * stride + 2);
      k2     = (t2 + stride - 1) / stride + l;
      ncyc   = t2 + (l + n + 3) * stride + 6;
      for (int c = 0; c < ncyc; c++) begin
         trig = (ecnt + 1 == r0 + t1) || (ecnt + 1 == r0 + t2);
         tick();
         trig = 1'b0;
         if (ecnt >= r0 + 1)
            check(din_status == 16'(ecnt + 99), "R3 status", int'(din_status), (ecnt + 99) & 16'hffff);
         begin
            bit          ev = 1'b0;
            logic [15:0] ed = '0;
            int          rel = ecnt - 1 - r0;
            if (rel >= 0 && (rel % stride) == 0) begin
               int k = rel / stride;
               ev = (k >= k1 && (s || k <= last1)) || (acc2 && k >= k2 && k <= k2 + n);
               ed = 16'(r0 + (k - h) * stride + 98);
            end
            // R1 R4 R5 R6 R7: window and spacing of forwarded words
            check(out_valid == ev, "R1 R4 R5 R6 R7 valid", int'(out_valid), int'(ev));
            // R2: history depth and latency
            if (ev && out_valid)
               check(out_data == ed, "R2 data", int'(out_data), int'(ed));
         end
      end
   endtask

   task automatic run_flush();
      int gap, c_edge;
      do_reset(0, 2, 0, 0, 1'b1, 1);
      for (int c = 0; c < 40; c++) begin
         trig = (ecnt + 1 == r0 + 20);
         tick();
         trig = 1'b0;
      end
      check(out_valid == 1'b1, "R7 streaming before flush", int'(out_valid), 1);
      check(out_data == 16'(ecnt + 97 - 2), "R2 data depth 2", int'(out_data), ecnt + 95);
      cfg_hist = 5'd3;
      c_edge = ecnt + 1;
      gap = 0;
      for (int c = 0; c < 20; c++) begin
         tick();
         if (out_valid) break;
         gap++;
      end
      // R8: flush cycle plus three refill words
      check(gap == 4, "R8 refill gap", gap, 4);
      check(ecnt == c_edge + 4, "R8 first valid edge", ecnt, c_edge + 4);
      check(out_data == 16'(ecnt + 97 - 3), "R8 R2 data after refill", int'(out_data), ecnt + 94);
      tick();
      check(out_valid == 1'b1 && out_data == 16'(ecnt + 94), "R7 R8 streaming resumes",
            int'(out_data), ecnt + 94);
   endtask

   initial begin
      int hl[3];
      hl[0] = 0; hl[1] = 1; hl[2] = 3;
      for (int d = 0; d < 3; d++)
         for (int hi = 0; hi < 3; hi++)
            for (int l = 0; l <= 2; l += 2)
               for (int n = 0; n <= 3; n += 3)
                  for (int s = 0; s < 2; s++)
                     for (int p = 1; p <= 2; p++)
                        run_case(d, hl[hi], l, n, s[0], p, 40,
                                 (((d + hi + n) % 2) == 0) ? 43 : 100);
      run_flush();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired at edge %0d: actual hung expected finished", ecnt);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule